// File: doc/BRIEF.md
# Multiprocessor Address Filter for a 9-bit Serial Receiver

This block sits behind the bit-level receiver of a 9-bit serial port used on a shared multi-drop line. Each time the receiver finishes a frame it presents the eight data bits and the ninth bit for one cycle. A frame whose ninth bit is 1 carries an address. A frame whose ninth bit is 0 carries data. The filter decides whether the frame should be handed on to software, and signals that decision with a one-cycle accept strobe. The strobe is what raises the receive interrupt.

Each slave holds an address register and a mask register. A mask bit of 0 makes that position don't-care in the comparison. This lets one slave answer on its own, or lets a group of slaves share one address. A second, broadcast comparison is formed from the OR of the two registers. In that comparison only the positions holding 1 must be 1 in the received byte.

The filter has two states. In ST_HUNT the slave waits to be addressed. In ST_SELECTED data frames pass through. The transitions are:
- HUNT to SELECTED on a matching address frame.
- SELECTED to HUNT on a non-matching address frame.
- Any state to HUNT whenever filtering is switched off.
- SELECTED to SELECTED on data frames and on matching address frames.

Top module: `mp_addr_filter`

## Requirements
- R1: While reset is asserted, and on the first clock after its release, `rx_accept` is 0 and the filter is in ST_HUNT, so a data frame is not accepted.
- R2: `rx_accept` is high for exactly the one cycle that follows a cycle with `frame_valid` high. It is never high after a cycle in which `frame_valid` is low.
- R3: Filtering is active only when `mode[1]` is 1 (`mode` = 2'b10 is the 9-bit fixed-rate mode, 2'b11 is the 9-bit variable-rate mode) and `mp_en` is 1. While filtering is inactive, every frame is accepted whatever its ninth bit and data.
- R4: With filtering active, an address frame (`rx_bit9` = 1) is accepted when `rx_data` equals `own_addr` in every position where `own_mask` is 1.
- R5: Positions where `own_mask` is 0 are ignored by the comparison in R4. With `own_mask` all zero, every address frame is accepted.
- R6: With filtering active, an address frame is also accepted when `rx_data` has a 1 in every position where `own_addr | own_mask` has a 1 (broadcast match).
- R7: With filtering active, an address frame that matches neither R4 nor R6 is rejected and moves the filter to ST_HUNT.
- R8: With filtering active, a data frame (`rx_bit9` = 0) is accepted in ST_SELECTED and rejected in ST_HUNT.
- R9: An accepted address frame moves the filter to ST_SELECTED. The filter stays there across any number of data frames.
- R10: Any cycle with filtering inactive returns the filter to ST_HUNT. A data frame that arrives after filtering is re-enabled is rejected until a matching address is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_valid | input | 1 | One-cycle pulse: a received frame is presented |
| rx_data | input | W (8) | Received eight data bits |
| rx_bit9 | input | 1 | Received ninth bit; 1 marks an address frame |
| mode | input | 2 | Serial mode select; bit 1 set selects a 9-bit mode |
| mp_en | input | 1 | Multiprocessor filtering enable |
| own_addr | input | W (8) | Slave address register |
| own_mask | input | W (8) | Slave mask register; 0 bits are don't-care |
| rx_accept | output | 1 | One-cycle strobe: frame accepted |

## Verification
Frames are first sent with filtering off, in both 8-bit and 9-bit modes, with both ninth-bit values. This separates a filter that wrongly blocks frames from one that passes them. A nibble-wide mask is then used with addresses chosen three ways: some match only through the masked comparison, some only through the broadcast comparison, and some through neither. These tell the two match paths apart and show where mask bits are ignored. Data frames are interleaved before selection, after selection and after deselection. This separates the two states. A final pass drops and restores the enable while the slave is selected, which shows whether the enable resets the selection.

// File: rtl/mpaf_pkg.sv
package mpaf_pkg;

    typedef enum logic [0:0] {
        ST_HUNT     = 1'b0,
        ST_SELECTED = 1'b1
    } mpaf_state_e;

    localparam int MPAF_MODE_W = 2;

endpackage

// File: rtl/mpaf_match.sv
module mpaf_match #(
    parameter int W = 8
) (
    input  logic [W-1:0] rx_data,
    input  logic [W-1:0] own_addr,
    input  logic [W-1:0] own_mask,
    output logic         given_hit,
    output logic         bcast_hit
);
    logic [W-1:0] bcast_pat;
    logic [W-1:0] given_ok;
    logic [W-1:0] bcast_ok;

    assign bcast_pat = own_addr | own_mask;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign given_ok[i] = ~own_mask[i] | ~(rx_data[i] ^ own_addr[i]);
        assign bcast_ok[i] = ~bcast_pat[i] | rx_data[i];
    end

    assign given_hit = &given_ok;
    assign bcast_hit = &bcast_ok;
endmodule

// File: rtl/mpaf_ctrl.sv
module mpaf_ctrl
    import mpaf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_valid,
    input  logic rx_bit9,
    input  logic filter_on,
    input  logic addr_hit,
    output logic accept
);
    mpaf_state_e state_q, state_d;
    logic        acc_d, acc_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HUNT;
        else        state_q <= state_d;
    end

    // next state and accept decision
    always_comb begin
        state_d = state_q;
        acc_d   = 1'b0;
        if (!filter_on) begin
            state_d = ST_HUNT;
            acc_d   = frame_valid;
        end else if (frame_valid) begin
            unique case (state_q)
                ST_HUNT: begin
                    if (rx_bit9 && addr_hit) begin
                        acc_d   = 1'b1;
                        state_d = ST_SELECTED;
                    end
                end
                ST_SELECTED: begin
                    if (rx_bit9) begin
                        acc_d   = addr_hit;
                        state_d = addr_hit ? ST_SELECTED : ST_HUNT;
                    end else begin
                        acc_d   = 1'b1;
                    end
                end
            endcase
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= 1'b0;
        else        acc_q <= acc_d;
    end

    assign accept = acc_q;
endmodule

// File: rtl/mp_addr_filter.sv
module mp_addr_filter
    import mpaf_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   frame_valid,
    input  logic [W-1:0]           rx_data,
    input  logic                   rx_bit9,
    input  logic [MPAF_MODE_W-1:0] mode,
    input  logic                   mp_en,
    input  logic [W-1:0]           own_addr,
    input  logic [W-1:0]           own_mask,
    output logic                   rx_accept
);
    logic given_hit, bcast_hit, filter_on;

    assign filter_on = mode[MPAF_MODE_W-1] & mp_en;

    mpaf_match #(.W(W)) match_i (
        .rx_data   (rx_data),
        .own_addr  (own_addr),
        .own_mask  (own_mask),
        .given_hit (given_hit),
        .bcast_hit (bcast_hit)
    );

    mpaf_ctrl ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_valid (frame_valid),
        .rx_bit9     (rx_bit9),
        .filter_on   (filter_on),
        .addr_hit    (given_hit | bcast_hit),
        .accept      (rx_accept)
    );
endmodule

// File: rtl/mp_addr_filter_chk.sv
module mp_addr_filter_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         frame_valid,
    input logic [W-1:0] rx_data,
    input logic         rx_bit9,
    input logic [1:0]   mode,
    input logic         mp_en,
    input logic [W-1:0] own_addr,
    input logic [W-1:0] own_mask,
    input logic         rx_accept
);
    AST_NO_STROBE_WITHOUT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_valid |=> !rx_accept); // R2

    AST_PASS_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && !(mode[1] && mp_en)) |=> rx_accept); // R3

    AST_EXACT_ADDR_ACCEPTED: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && mode[1] && mp_en && rx_bit9 && rx_data == own_addr) |=> rx_accept); // R4

    AST_ALL_ONES_BROADCAST: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && mode[1] && mp_en && rx_bit9 && (&rx_data)) |=> rx_accept); // R6

    AST_REENABLE_DESELECTS: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && mode[1] && mp_en && !rx_bit9 && !$past(mode[1] && mp_en)) |=> !rx_accept); // R10
endmodule

bind mp_addr_filter mp_addr_filter_chk #(.W(W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_valid (frame_valid),
    .rx_data     (rx_data),
    .rx_bit9     (rx_bit9),
    .mode        (mode),
    .mp_en       (mp_en),
    .own_addr    (own_addr),
    .own_mask    (own_mask),
    .rx_accept   (rx_accept)
);

// File: tb/mp_addr_filter_tb.sv
module mp_addr_filter_tb_top;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         frame_valid = 1'b0;
    logic [W-1:0] rx_data = '0;
    logic         rx_bit9 = 1'b0;
    logic [1:0]   mode = 2'b00;
    logic         mp_en = 1'b0;
    logic [W-1:0] own_addr = '0;
    logic [W-1:0] own_mask = '0;
    logic         rx_accept;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    always #4 clk = ~clk;  // 125 MHz

    mp_addr_filter #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .rx_data(rx_data),
        .rx_bit9(rx_bit9), .mode(mode), .mp_en(mp_en), .own_addr(own_addr),
        .own_mask(own_mask), .rx_accept(rx_accept)
    );

    // behavioural reference
    bit m_sel = 1'b0;
    bit m_acc = 1'b0;

    function automatic bit ref_hit(input logic [W-1:0] d, a, m);
        bit g = 1'b1;
        bit b = 1'b1;
        for (int i = 0; i < W; i++) begin
            if (m[i] && d[i] != a[i]) g = 1'b0;
            if ((a[i] || m[i]) && !d[i]) b = 1'b0;
        end
        return g || b;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sel = 1'b0;
            m_acc = 1'b0;
        end else if (!(mode[1] && mp_en)) begin
            m_sel = 1'b0;
            m_acc = frame_valid;
        end else if (frame_valid && rx_bit9) begin
            m_sel = ref_hit(rx_data, own_addr, own_mask);
            m_acc = m_sel;
        end else begin
            m_acc = frame_valid && m_sel;
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (rx_accept !== m_acc) begin
                errors++;
                $display("FAIL %s: rx_accept actual=%0b expected=%0b at %0t",
                         (rst_n ? cur_req : "R1"), rx_accept, m_acc, $time);
            end
        end
    end

    task automatic send(input logic [W-1:0] d, input logic b9, input string req);
        @(posedge clk); #1;
        cur_req     = req;
        rx_data     = d;
        rx_bit9     = b9;
        frame_valid = 1'b1;
        @(posedge clk); #1;
        frame_valid = 1'b0;
        @(posedge clk); #1;
    endtask

    task automatic summary;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run finished actual=0 expected=1");
            summary();
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        mode = 2'b11; mp_en = 1'b1;
        own_addr = 8'h5A; own_mask = 8'hF0;
        send(8'h00, 1'b0, "R1");          // data just after reset, not selected

        // R3: filtering off in several ways
        mode = 2'b01; mp_en = 1'b1;
        send(8'h12, 1'b1, "R3");
        send(8'h34, 1'b0, "R3");
        mode = 2'b10; mp_en = 1'b0;
        send(8'h99, 1'b1, "R3");
        send(8'h77, 1'b0, "R3");
        mode = 2'b00; mp_en = 1'b0;
        send(8'hC3, 1'b0, "R3");

        // R8: data rejected while hunting
        mode = 2'b11; mp_en = 1'b1;
        send(8'h42, 1'b0, "R8");
        // R4/R5: upper nibble matches, low nibble don't-care
        send(8'h53, 1'b1, "R4");
        // R9: stays selected over data
        send(8'h01, 1'b0, "R9");
        send(8'h02, 1'b0, "R9");
        send(8'h03, 1'b0, "R9");
        // R7: mismatch, neither given nor broadcast (0x33 lacks bits of 0xFA)
        send(8'h33, 1'b1, "R7");
        send(8'h04, 1'b0, "R7");
        // R6: broadcast only (0xFE covers 0xFA; upper nibble differs from 5)
        send(8'hFE, 1'b1, "R6");
        send(8'h05, 1'b0, "R6");
        // R7: mismatch deselects from selected state
        send(8'h0A, 1'b1, "R7");
        send(8'h06, 1'b0, "R8");

        // R5: mask all zero accepts any address
        own_mask = 8'h00;
        send(8'h00, 1'b1, "R5");
        send(8'h3C, 1'b1, "R5");
        own_addr = 8'h81; own_mask = 8'hFF;
        send(8'h81, 1'b1, "R4");
        send(8'h80, 1'b1, "R7");

        // R10: drop the enable while selected
        send(8'h81, 1'b1, "R9");
        mp_en = 1'b0;
        @(posedge clk); #1;
        mp_en = 1'b1;
        send(8'h07, 1'b0, "R10");
        mode = 2'b01;
        @(posedge clk); #1;
        mode = 2'b10;
        send(8'h81, 1'b1, "R4");
        mode = 2'b01;
        @(posedge clk); #1;
        mode = 2'b11;
        send(8'h08, 1'b0, "R10");

        // R2: idle stretch, no strobes
        cur_req = "R2";
        repeat (10) @(posedge clk);
        @(negedge clk);
        #1 summary();
    end
endmodule